// File: doc/BRIEF.md
# Two-Wire Bus Clock Generator

This block produces the serial clock for the master side of a two-wire bus, timed from the system clock. Software-side logic provides an 8-bit rate value R and a 2-bit prescale code P. Together they set a half period of H = 8 + R·4^P system clocks. An undisturbed bus period is therefore 2H clocks, or 16 + 2·R·4^P. The block drives the clock line only as an open-drain pull-down enable. It reads the actual line level back through a synchronizer and a glitch filter. This lets a slave that keeps the line low lengthen the low part of the clock.

Each high-to-low and low-to-high transition it makes is marked by a one-cycle strobe, for use by a separate byte shifter. A new rate or prescale value is captured only when a period begins, so changing the setting never produces a short phase. When the enable is low, the line is released and the block stays silent.

Top module: `twi_sclk_gen`

## Requirements
- R1: After reset, `scl_oe_o`, `fall_stb_o` and `rise_stb_o` are all 0.
- R2: With nothing stretching the line, the distance between consecutive `fall_stb_o` pulses is 2H clocks, where H = 8 + R·M. The multiplier M is 1, 4, 16 or 64 for `prescale_i` codes 0, 1, 2 and 3.
- R3: In each period, `scl_oe_o` is 1 for exactly H consecutive clocks. `rise_stb_o` pulses H clocks after the `fall_stb_o` pulse of the same period.
- R4: Each strobe lasts one clock. `fall_stb_o` is high in the first cycle where `scl_oe_o` is 1, and `rise_stb_o` is high in the first cycle where `scl_oe_o` is 0 after a low phase. The two strobes are never high together.
- R5: From the idle state, `scl_oe_o` and `fall_stb_o` go to 1 on the first clock edge at which `enable_i` is sampled as 1.
- R6: If the line stays low after the block releases it, no new period starts while it stays low. `scl_oe_o` is asserted again exactly H clocks after the clock edge that follows the line going high.
- R7: The filtered line level changes only after FILT_W (default 3) consecutive samples that disagree with it. A high spike shorter than FILT_W clocks during a stretch does not end the stretch.
- R8: `rate_i` and `prescale_i` are captured only when a period starts. A change during a period takes effect from the next period.
- R9: With R = 0, the period is 16 clocks whatever the prescale code.
- R10: When `enable_i` drops during a period, `scl_oe_o` is 0 from the next clock edge, and no strobe pulses while the enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Master mode enable; 0 releases the line |
| rate_i | input | 8 | Rate value R |
| prescale_i | input | 2 | Prescale code P (multiplier 4^P) |
| scl_i | input | 1 | Raw clock line level read back from the pad |
| scl_oe_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| fall_stb_o | output | 1 | One-cycle pulse when a low phase begins |
| rise_stb_o | output | 1 | One-cycle pulse when the line is released |

## Verification
The hardest condition to reach is the high-phase counter stalled at its wait point while the filter still reads low. A short spike must then arrive during the stall, and a clean release must follow it. The bench models the bus as a wired-AND of the block's pull-down and a slave hold signal. It asserts the hold at the start of a low phase so that the release finds the line still low. It then opens the hold for fewer cycles than the filter width, and afterwards releases it at a known edge. The delay to the next low phase is counted from that edge.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sclk_state_e;

    localparam int unsigned HALF_BASE = 8;

endpackage

// File: rtl/sclk_half_calc.sv
module sclk_half_calc #(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned PRE_W  = 2,
    parameter int unsigned BASE   = 8,
    parameter int unsigned HW     = 15
) (
    input  logic [RATE_W-1:0] rate_i,
    input  logic [PRE_W-1:0]  pre_i,
    output logic [HW-1:0]     half_o
);
    localparam int unsigned NCODE = 1 << PRE_W;

    logic [HW-1:0] cand [NCODE];

    // candidate half length for every prescale code: BASE + rate * 4^code
    for (genvar g = 0; g < NCODE; g++) begin : g_code
        assign cand[g] = HW'(BASE) + (HW'(rate_i) << (2 * g));
    end

    assign half_o = cand[pre_i];

endmodule

// File: rtl/sclk_deglitch.sv
module sclk_deglitch #(
    parameter int unsigned FILT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CW = $clog2(FILT_W + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          out;
    } dg_t;

    dg_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        if (q.sync[1] == q.out) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_W - 1)) begin
            d.out = q.sync[1];
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sync: 2'b11, cnt: '0, out: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign filt_o = q.out;

    // R7: the output only moves toward a level the synchronizer reported
    a_r7_flip_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.out) |-> ($past(q.sync[1]) == q.out));

    // R7: a flip needs a full run of disagreeing samples behind it
    a_r7_flip_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.out) |-> ($past(q.cnt) == CW'(FILT_W - 1)));

endmodule

// File: rtl/twi_sclk_gen.sv
module twi_sclk_gen
    import sclk_pkg::*;
#(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned PRE_W  = 2,
    parameter int unsigned FILT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [PRE_W-1:0]  prescale_i,
    input  logic              scl_i,
    output logic              scl_oe_o,
    output logic              fall_stb_o,
    output logic              rise_stb_o
);
    localparam int unsigned SHIFT_MAX = 2 * ((1 << PRE_W) - 1);
    localparam int unsigned HW        = RATE_W + SHIFT_MAX + 1;
    // high-phase count at which the released line is first visible through
    // two sync flops plus FILT_W filter samples (FILT_W must be 1..4)
    localparam int unsigned LAT       = FILT_W + 2;

    typedef struct packed {
        sclk_state_e   state;
        logic [HW-1:0] half;
        logic [HW-1:0] cnt;
        logic          oe;
        logic          fall;
        logic          rise;
    } gen_t;

    gen_t          q, d;
    logic [HW-1:0] half_new;
    logic          scl_filt;

    sclk_half_calc #(
        .RATE_W (RATE_W),
        .PRE_W  (PRE_W),
        .BASE   (HALF_BASE),
        .HW     (HW)
    ) u_calc (
        .rate_i (rate_i),
        .pre_i  (prescale_i),
        .half_o (half_new)
    );

    sclk_deglitch #(
        .FILT_W (FILT_W)
    ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (scl_i),
        .filt_o (scl_filt)
    );

    always_comb begin
        d      = q;
        d.fall = 1'b0;
        d.rise = 1'b0;
        if (!enable_i) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    d.state = ST_LOW;
                    d.oe    = 1'b1;
                    d.fall  = 1'b1;
                    d.cnt   = '0;
                    d.half  = half_new;
                end
                ST_LOW: begin
                    if (q.cnt == q.half - 1'b1) begin
                        d.state = ST_HIGH;
                        d.oe    = 1'b0;
                        d.rise  = 1'b1;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (q.cnt == q.half - 1'b1) begin
                        d.state = ST_LOW;
                        d.oe    = 1'b1;
                        d.fall  = 1'b1;
                        d.cnt   = '0;
                        d.half  = half_new;
                    end else if (!scl_filt && (q.cnt == HW'(LAT))) begin
                        d.cnt = q.cnt;           // line still held low: stretch
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    d.state = ST_IDLE;
                    d.oe    = 1'b0;
                    d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, half: HW'(HALF_BASE), cnt: '0,
                   oe: 1'b0, fall: 1'b0, rise: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_oe_o   = q.oe;
    assign fall_stb_o = q.fall;
    assign rise_stb_o = q.rise;

    // R4: strobes never coincide
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb_o && rise_stb_o));

    // R4: the fall strobe marks the first pulled cycle
    a_r4_fall_on_pull: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb_o |-> (scl_oe_o && !$past(scl_oe_o)));

    // R4: the rise strobe marks the first released cycle after a low phase
    a_r4_rise_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb_o |-> (!scl_oe_o && $past(scl_oe_o)));

    // R10: a low enable leaves the line released and the strobes quiet
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable_i) |-> (!scl_oe_o && !fall_stb_o && !rise_stb_o));

    // R3: the low-phase counter stays inside the captured half length
    a_r3_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_LOW) |-> (q.cnt < q.half));

    // R8: the captured half length moves only when a period starts
    a_r8_half_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb_o |-> $stable(q.half));

    // R6: the high-phase count stalls only while the filtered line reads low
    a_r6_stall_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_HIGH) && ($past(q.state) == ST_HIGH) && $stable(q.cnt))
            |-> !$past(scl_filt));

endmodule

// File: tb/sim_twi_sclk_gen.sv
module sim_twi_sclk_gen;

    localparam int FW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] rate = 8'd0;
    logic [1:0] pre = 2'd0;
    logic       hold = 1'b0;
    logic       scl_oe, fall_stb, rise_stb;
    logic       scl_line;

    int total = 0;
    int bad = 0;

    // wired-AND bus: block pull-down and slave pull-down
    assign scl_line = ~(scl_oe | hold);

    always #5 clk = ~clk;

    twi_sclk_gen #(.RATE_W(8), .PRE_W(2), .FILT_W(FW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .rate_i     (rate),
        .prescale_i (pre),
        .scl_i      (scl_line),
        .scl_oe_o   (scl_oe),
        .fall_stb_o (fall_stb),
        .rise_stb_o (rise_stb)
    );

    function automatic int exp_half(int r, int p);
        return 8 + r * (1 << (2 * p));
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_fall();
        int w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!fall_stb && w < 70000);
    endtask

    // starts on a negedge showing fall_stb, ends on the next one
    task automatic span(output int per, output int low, output int rpos);
        per = 0; low = 1; rpos = -1;
        forever begin
            @(negedge clk);
            per++;
            if (fall_stb || per > 70000) break;
            if (scl_oe) low++;
            if (rise_stb) rpos = per;
        end
    endtask

    task automatic restart(int r, int p);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        rate = 8'(r);
        pre  = 2'(p);
        enable = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "scl_oe after reset", int'(scl_oe), 0);
        chk("R1", "fall_stb after reset", int'(fall_stb), 0);
        chk("R1", "rise_stb after reset", int'(rise_stb), 0);
    endtask

    task automatic t_start();
        rate = 8'd2; pre = 2'd0;
        enable = 1'b1;
        @(negedge clk);
        chk("R5", "scl_oe one edge after enable", int'(scl_oe), 1);
        chk("R5", "fall_stb one edge after enable", int'(fall_stb), 1);
    endtask

    task automatic t_rate(int r, int p, string req);
        int per, low, rpos, h;
        h = exp_half(r, p);
        restart(r, p);
        wait_fall();
        span(per, low, rpos);
        chk(req, $sformatf("period r=%0d p=%0d", r, p), per, 2 * h);
        chk("R3", $sformatf("low length r=%0d p=%0d", r, p), low, h);
        chk("R3", $sformatf("rise position r=%0d p=%0d", r, p), rpos, h);
    endtask

    task automatic t_change();
        int per, low, rpos;
        restart(1, 0);
        wait_fall();
        rate = 8'd2;                     // mid-period change
        span(per, low, rpos);
        chk("R8", "period with old setting", per, 18);
        span(per, low, rpos);
        chk("R8", "period with new setting", per, 20);
    endtask

    task automatic t_stretch();
        int per, low, rpos, k, falls;
        restart(0, 0);
        wait_fall();
        hold = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!rise_stb && k < 100);
        falls = 0;
        repeat (20) begin
            @(negedge clk);
            if (fall_stb || scl_oe) falls++;
        end
        chk("R6", "no new period while held", falls, 0);
        // spike shorter than the filter width
        hold = 1'b0;
        repeat (FW - 1) @(negedge clk);
        hold = 1'b1;
        falls = 0;
        repeat (20) begin
            @(negedge clk);
            if (fall_stb || scl_oe) falls++;
        end
        chk("R7", "short spike ignored", falls, 0);
        hold = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (!fall_stb && k < 100);
        chk("R6", "delay from line high to pull", k, 8);
        span(per, low, rpos);
        chk("R6", "period after stretch ends", per, 16);
    endtask

    task automatic t_disable();
        int per, low, rpos, act;
        restart(5, 0);
        wait_fall();
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R10", "scl_oe after disable", int'(scl_oe), 0);
        act = 0;
        repeat (12) begin
            if (fall_stb || rise_stb || scl_oe) act++;
            @(negedge clk);
        end
        chk("R10", "activity while disabled", act, 0);
        enable = 1'b1;
        @(negedge clk);
        chk("R5", "restart fall_stb", int'(fall_stb), 1);
        span(per, low, rpos);
        chk("R2", "period after re-enable", per, 26);
    endtask

    initial begin
        t_reset();
        t_start();
        t_rate(0, 0, "R9");
        t_rate(0, 3, "R9");
        t_rate(3, 1, "R2");
        t_rate(1, 2, "R2");
        t_rate(2, 3, "R2");
        t_rate(255, 3, "R2");
        t_change();
        t_stretch();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule